// File: doc/BRIEF.md
# Single-Outstanding Completer Bridge

This block sits behind the receive side of a PCIe endpoint. It takes single-dword memory requests, each already parsed into a kind code, an address, byte enables, a requester ID, a tag and write data. It turns each request into one access on a 32-bit memory-mapped master bus that uses wait-request flow control. For every request that needs an answer, it builds a completion descriptor for the transmit side.

The bridge keeps exactly one transaction in flight. A write frees the request port as soon as the bus has taken it. A read, an unsupported request and a zero-length flush read hold the port closed until their completion has been handed over. The incoming address is mapped into the local bus space through a window mask and a local base. The mask and base are sampled when the request is accepted.

Top module: `cb_bridge`

## Requirements
- R1: Out of reset `req_ready` is 1, `bus_read`, `bus_write` and `cpl_valid` are 0. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle until that request is finished, `req_ready` stays 0, and exactly one of `req_ready`, `bus_read`, `bus_write` and `cpl_valid` is 1 in every cycle.
- R2: A request with `req_kind` = 2'b00 and nonzero byte enables is a read. It raises `bus_read` in the cycle after acceptance. On the first edge where `bus_waitreq` is 0, `bus_rdata` is captured. The next cycle then presents `cpl_valid` with `cpl_status` = 3'b000, `cpl_has_data` = 1 and `cpl_data` equal to the captured word. `req_ready` returns only in the cycle after the edge where `cpl_valid` and `cpl_ready` are both 1.
- R3: A request with `req_kind` = 2'b01 is a write. It raises `bus_write` with `bus_wdata` equal to `req_wdata`. On the first edge where `bus_waitreq` is 0, `bus_write` drops and `req_ready` rises in the next cycle. A write produces no completion.
- R4: While the bus is driven, `bus_addr` equals `(req_addr & win_mask) | (win_base & ~win_mask)` with its two low bits forced to 0. `win_mask` and `win_base` are the values present at the accepting edge.
- R5: `bus_be` equals the accepted `req_be` unchanged, for reads and writes alike.
- R6: A request with `req_kind` of 2'b10 or 2'b11 makes no bus access. It gives a completion with `cpl_status` = 3'b100 (completer abort) and `cpl_has_data` = 0, presented in the cycle after acceptance.
- R7: A read with `req_be` = 4'b0000 is a flush. It makes no bus access and gives a completion in the cycle after acceptance, with `cpl_status` = 3'b000, `cpl_has_data` = 0 and `cpl_byte_cnt` = 1.
- R8: Every completion carries the accepted `req_rid` and `req_tag`. `cpl_lo_addr` is `{req_addr[6:2], i}`, where i is the index of the lowest set byte enable (0 when none is set). `cpl_byte_cnt` is (highest set index − lowest set index + 1), or 1 when no enable is set.
- R9: While `bus_read` or `bus_write` is 1 and `bus_waitreq` is 1, the next cycle keeps the same strobe and the same `bus_addr`, `bus_be` and `bus_wdata`.
- R10: While `cpl_valid` is 1 and `cpl_ready` is 0, the next cycle keeps `cpl_valid` and every completion field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_mask | input | 32 | Address bits that pass through translation |
| win_base | input | 32 | Local base used for bits outside the mask |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_kind | input | 2 | 00 read, 01 write, 10/11 unsupported |
| req_addr | input | 32 | Request byte address |
| req_be | input | 4 | Request byte enables |
| req_rid | input | 16 | Requester ID |
| req_tag | input | 8 | Request tag |
| req_wdata | input | 32 | Write data |
| bus_addr | output | 32 | Translated dword-aligned bus address |
| bus_read | output | 1 | Bus read strobe |
| bus_write | output | 1 | Bus write strobe |
| bus_be | output | 4 | Bus byte enables |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data, valid when wait-request is low |
| bus_waitreq | input | 1 | Bus stall |
| cpl_valid | output | 1 | Completion descriptor present |
| cpl_ready | input | 1 | Transmit side takes the completion |
| cpl_status | output | 3 | 000 success, 100 completer abort |
| cpl_has_data | output | 1 | Completion carries a data word |
| cpl_data | output | 32 | Completion data word |
| cpl_rid | output | 16 | Echoed requester ID |
| cpl_tag | output | 8 | Echoed tag |
| cpl_lo_addr | output | 7 | Lower address of the completion |
| cpl_byte_cnt | output | 3 | Byte count of the completion |

## Verification
The hardest case is a new request waiting on the port while the previous one is still stalled: a read held by wait-request, or a completion held back by the transmit side. At the same moment the translation window is being reprogrammed. Only then do the release points and the sampling of the window at acceptance show up. The stimulus therefore keeps `req_valid` high most of the time and changes the window at random cycles. It runs in phases where wait-request and completion backpressure are asserted with rising probability, so that long stalls overlap fresh requests and window changes.

// File: rtl/cb_pkg.sv
package cb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_CPL  = 2'd3
    } cb_state_e;

    localparam logic [1:0] KIND_RD = 2'b00;
    localparam logic [1:0] KIND_WR = 2'b01;

    localparam logic [2:0] CPL_SC = 3'b000;
    localparam logic [2:0] CPL_CA = 3'b100;
endpackage

// File: rtl/cb_addr_xlate.sv
module cb_addr_xlate #(
    parameter int ADDR_W = 32,
    parameter int BE_W   = 4
) (
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [ADDR_W-1:0] mask,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] out_addr
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BE_W - 1);

    always_comb begin
        out_addr = ((in_addr & mask) | (base & ~mask)) & ALIGN_MASK;
    end
endmodule

// File: rtl/cb_be_span.sv
module cb_be_span #(
    parameter int BE_W = 4,
    localparam int IDX_W = $clog2(BE_W),
    localparam int BC_W  = $clog2(BE_W) + 1
) (
    input  logic [BE_W-1:0]  be,
    output logic [IDX_W-1:0] first_idx,
    output logic [BC_W-1:0]  byte_cnt
);
    logic [IDX_W-1:0] last_idx;
    logic             any_set;

    always_comb begin
        first_idx = '0;
        last_idx  = '0;
        any_set   = 1'b0;
        for (int i = 0; i < BE_W; i++) begin
            if (be[i]) begin
                if (!any_set) begin
                    first_idx = IDX_W'(i);
                end
                any_set  = 1'b1;
                last_idx = IDX_W'(i);
            end
        end
        if (any_set) begin
            byte_cnt = BC_W'(last_idx) - BC_W'(first_idx) + BC_W'(1);
        end else begin
            byte_cnt = BC_W'(1);
        end
    end
endmodule

// File: rtl/cb_bridge.sv
module cb_bridge
    import cb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int RID_W     = 16,
    parameter int TAG_W     = 8,
    parameter int LOADDR_W  = 7,
    localparam int BE_W     = DATA_W / 8,
    localparam int IDX_W    = $clog2(BE_W),
    localparam int BC_W     = $clog2(BE_W) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   win_mask,
    input  logic [ADDR_W-1:0]   win_base,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_kind,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [BE_W-1:0]     req_be,
    input  logic [RID_W-1:0]    req_rid,
    input  logic [TAG_W-1:0]    req_tag,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                bus_read,
    output logic                bus_write,
    output logic [BE_W-1:0]     bus_be,
    output logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W-1:0]   bus_rdata,
    input  logic                bus_waitreq,
    output logic                cpl_valid,
    input  logic                cpl_ready,
    output logic [2:0]          cpl_status,
    output logic                cpl_has_data,
    output logic [DATA_W-1:0]   cpl_data,
    output logic [RID_W-1:0]    cpl_rid,
    output logic [TAG_W-1:0]    cpl_tag,
    output logic [LOADDR_W-1:0] cpl_lo_addr,
    output logic [BC_W-1:0]     cpl_byte_cnt
);
    typedef struct packed {
        cb_state_e           st;
        logic [ADDR_W-1:0]   addr;
        logic [BE_W-1:0]     be;
        logic [DATA_W-1:0]   wdata;
        logic [RID_W-1:0]    rid;
        logic [TAG_W-1:0]    tag;
        logic [2:0]          status;
        logic                has_data;
        logic [DATA_W-1:0]   data;
        logic [LOADDR_W-1:0] lo;
        logic [BC_W-1:0]     bc;
    } cb_regs_t;

    cb_regs_t r_d, r_q;

    logic [ADDR_W-1:0] xl_addr;
    logic [IDX_W-1:0]  span_first;
    logic [BC_W-1:0]   span_cnt;

    cb_addr_xlate #(
        .ADDR_W (ADDR_W),
        .BE_W   (BE_W)
    ) i_xlate (
        .in_addr  (req_addr),
        .mask     (win_mask),
        .base     (win_base),
        .out_addr (xl_addr)
    );

    cb_be_span #(
        .BE_W (BE_W)
    ) i_span (
        .be        (req_be),
        .first_idx (span_first),
        .byte_cnt  (span_cnt)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr     = xl_addr;
                    r_d.be       = req_be;
                    r_d.wdata    = req_wdata;
                    r_d.rid      = req_rid;
                    r_d.tag      = req_tag;
                    r_d.lo       = {req_addr[LOADDR_W-1:IDX_W], span_first};
                    r_d.bc       = span_cnt;
                    r_d.status   = CPL_SC;
                    r_d.has_data = 1'b0;
                    r_d.data     = '0;
                    if (req_kind == KIND_WR) begin
                        r_d.st = ST_WR;
                    end else if (req_kind == KIND_RD) begin
                        r_d.st = (|req_be) ? ST_RD : ST_CPL;
                    end else begin
                        r_d.status = CPL_CA;
                        r_d.st     = ST_CPL;
                    end
                end
            end
            ST_RD: begin
                if (!bus_waitreq) begin
                    r_d.data     = bus_rdata;
                    r_d.has_data = 1'b1;
                    r_d.st       = ST_CPL;
                end
            end
            ST_WR: begin
                if (!bus_waitreq) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_CPL: begin
                if (cpl_ready) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready    = (r_q.st == ST_IDLE);
    assign bus_read     = (r_q.st == ST_RD);
    assign bus_write    = (r_q.st == ST_WR);
    assign bus_addr     = r_q.addr;
    assign bus_be       = r_q.be;
    assign bus_wdata    = r_q.wdata;
    assign cpl_valid    = (r_q.st == ST_CPL);
    assign cpl_status   = r_q.status;
    assign cpl_has_data = r_q.has_data;
    assign cpl_data     = r_q.data;
    assign cpl_rid      = r_q.rid;
    assign cpl_tag      = r_q.tag;
    assign cpl_lo_addr  = r_q.lo;
    assign cpl_byte_cnt = r_q.bc;
endmodule

// File: rtl/cb_bridge_chk.sv
module cb_bridge_chk #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int RID_W     = 16,
    parameter int TAG_W     = 8,
    parameter int LOADDR_W  = 7,
    localparam int BE_W     = DATA_W / 8,
    localparam int IDX_W    = $clog2(BE_W),
    localparam int BC_W     = $clog2(BE_W) + 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_ready,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_read,
    input logic                bus_write,
    input logic [BE_W-1:0]     bus_be,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                bus_waitreq,
    input logic                cpl_valid,
    input logic                cpl_ready,
    input logic [2:0]          cpl_status,
    input logic                cpl_has_data,
    input logic [DATA_W-1:0]   cpl_data,
    input logic [RID_W-1:0]    cpl_rid,
    input logic [TAG_W-1:0]    cpl_tag,
    input logic [LOADDR_W-1:0] cpl_lo_addr,
    input logic [BC_W-1:0]     cpl_byte_cnt
);
    p_one_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({req_ready, bus_read, bus_write, cpl_valid}) == 1);

    p_rd_to_cpl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read && !bus_waitreq) |=>
            (cpl_valid && cpl_has_data && cpl_status == 3'b000 &&
             cpl_data == $past(bus_rdata)));

    p_cpl_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready) |=> req_ready);

    p_wr_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write && !bus_waitreq) |=> (req_ready && !cpl_valid));

    p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read || bus_write) |-> (bus_addr[IDX_W-1:0] == '0));

    p_abort_nodata_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_status == 3'b100) |-> !cpl_has_data);

    p_flush_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_has_data && cpl_status == 3'b000) |->
            (cpl_byte_cnt == BC_W'(1)));

    p_bus_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_read || bus_write) && bus_waitreq) |=>
            ($stable(bus_read) && $stable(bus_write) && $stable(bus_addr) &&
             $stable(bus_be) && $stable(bus_wdata)));

    p_cpl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=>
            (cpl_valid && $stable(cpl_status) && $stable(cpl_has_data) &&
             $stable(cpl_data) && $stable(cpl_rid) && $stable(cpl_tag) &&
             $stable(cpl_lo_addr) && $stable(cpl_byte_cnt)));
endmodule

bind cb_bridge cb_bridge_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RID_W    (RID_W),
    .TAG_W    (TAG_W),
    .LOADDR_W (LOADDR_W)
) i_cb_bridge_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .bus_addr     (bus_addr),
    .bus_read     (bus_read),
    .bus_write    (bus_write),
    .bus_be       (bus_be),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .bus_waitreq  (bus_waitreq),
    .cpl_valid    (cpl_valid),
    .cpl_ready    (cpl_ready),
    .cpl_status   (cpl_status),
    .cpl_has_data (cpl_has_data),
    .cpl_data     (cpl_data),
    .cpl_rid      (cpl_rid),
    .cpl_tag      (cpl_tag),
    .cpl_lo_addr  (cpl_lo_addr),
    .cpl_byte_cnt (cpl_byte_cnt)
);

// File: tb/test_cb_bridge.sv
module test_cb_bridge;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] win_mask = '0;
    logic [31:0] win_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [15:0] req_rid = '0;
    logic [7:0]  req_tag = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] bus_addr;
    logic        bus_read;
    logic        bus_write;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_waitreq = 1'b0;
    logic        cpl_valid;
    logic        cpl_ready = 1'b0;
    logic [2:0]  cpl_status;
    logic        cpl_has_data;
    logic [31:0] cpl_data;
    logic [15:0] cpl_rid;
    logic [7:0]  cpl_tag;
    logic [6:0]  cpl_lo_addr;
    logic [2:0]  cpl_byte_cnt;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cb_bridge i_cb_bridge (
        .clk (clk), .rst_n (rst_n),
        .win_mask (win_mask), .win_base (win_base),
        .req_valid (req_valid), .req_ready (req_ready), .req_kind (req_kind),
        .req_addr (req_addr), .req_be (req_be), .req_rid (req_rid),
        .req_tag (req_tag), .req_wdata (req_wdata),
        .bus_addr (bus_addr), .bus_read (bus_read), .bus_write (bus_write),
        .bus_be (bus_be), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .bus_waitreq (bus_waitreq),
        .cpl_valid (cpl_valid), .cpl_ready (cpl_ready), .cpl_status (cpl_status),
        .cpl_has_data (cpl_has_data), .cpl_data (cpl_data), .cpl_rid (cpl_rid),
        .cpl_tag (cpl_tag), .cpl_lo_addr (cpl_lo_addr), .cpl_byte_cnt (cpl_byte_cnt)
    );

    // Reference model: 0 waiting for a request, 1 reading, 2 writing, 3 completing
    int          m_phase = 0;
    logic [31:0] m_addr, m_wdata, m_data;
    logic [3:0]  m_be;
    logic [15:0] m_rid;
    logic [7:0]  m_tag;
    logic [2:0]  m_status;
    logic        m_has;
    logic [6:0]  m_lo;
    logic [2:0]  m_bc;

    function automatic void be_span(input logic [3:0] be, output int lo_i, output int cnt);
        int hi_i;
        lo_i = -1;
        hi_i = 0;
        for (int i = 0; i < 4; i++) begin
            if (be[i]) begin
                if (lo_i < 0) lo_i = i;
                hi_i = i;
            end
        end
        if (lo_i < 0) begin
            lo_i = 0;
            cnt  = 1;
        end else begin
            cnt = hi_i - lo_i + 1;
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0;
        end else begin
            case (m_phase)
                0: if (req_valid) begin
                    int li, cn;
                    be_span(req_be, li, cn);
                    m_addr   = ((req_addr & win_mask) | (win_base & ~win_mask)) & 32'hFFFF_FFFC;
                    m_be     = req_be;
                    m_wdata  = req_wdata;
                    m_rid    = req_rid;
                    m_tag    = req_tag;
                    m_lo     = {req_addr[6:2], 2'(li)};
                    m_bc     = 3'(cn);
                    m_has    = 1'b0;
                    m_status = 3'b000;
                    if (req_kind == 2'b01) m_phase = 2;
                    else if (req_kind == 2'b00) m_phase = (req_be != 0) ? 1 : 3;
                    else begin
                        m_status = 3'b100;
                        m_phase  = 3;
                    end
                end
                1: if (!bus_waitreq) begin
                    m_data  = bus_rdata;
                    m_has   = 1'b1;
                    m_phase = 3;
                end
                2: if (!bus_waitreq) m_phase = 0;
                3: if (cpl_ready) m_phase = 0;
                default: m_phase = 0;
            endcase
        end
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R1 req_ready", 64'(req_ready), 64'(m_phase == 0));
        chk("R2 bus_read", 64'(bus_read), 64'(m_phase == 1));
        chk("R3 bus_write", 64'(bus_write), 64'(m_phase == 2));
        chk("R6 R7 cpl_valid", 64'(cpl_valid), 64'(m_phase == 3));
        if (m_phase == 1 || m_phase == 2) begin
            chk("R4 R9 bus_addr", 64'(bus_addr), 64'(m_addr));
            chk("R5 R9 bus_be", 64'(bus_be), 64'(m_be));
            if (m_phase == 2) chk("R3 R9 bus_wdata", 64'(bus_wdata), 64'(m_wdata));
        end
        if (m_phase == 3) begin
            chk("R6 R10 cpl_status", 64'(cpl_status), 64'(m_status));
            chk("R7 R10 cpl_has_data", 64'(cpl_has_data), 64'(m_has));
            if (m_has) chk("R2 R10 cpl_data", 64'(cpl_data), 64'(m_data));
            chk("R8 cpl_rid", 64'(cpl_rid), 64'(m_rid));
            chk("R8 cpl_tag", 64'(cpl_tag), 64'(m_tag));
            chk("R8 cpl_lo_addr", 64'(cpl_lo_addr), 64'(m_lo));
            chk("R8 R7 cpl_byte_cnt", 64'(cpl_byte_cnt), 64'(m_bc));
        end
    endtask

    task automatic drive_random(input int stall_pct);
        int k;
        req_valid = ($urandom % 4) != 0;
        k = $urandom % 8;
        if (k < 4) req_kind = 2'b00;
        else if (k < 7) req_kind = 2'b01;
        else req_kind = ($urandom % 2 == 0) ? 2'b10 : 2'b11;
        req_be    = ($urandom % 5 == 0) ? 4'b0000 : 4'($urandom);
        req_addr  = $urandom;
        req_wdata = $urandom;
        req_rid   = 16'($urandom);
        req_tag   = 8'($urandom);
        bus_rdata = $urandom;
        bus_waitreq = int'($urandom % 100) < stall_pct;
        cpl_ready   = int'($urandom % 100) >= stall_pct;
        if ($urandom % 40 == 0) begin
            win_mask = 32'hFFFF_FFFF >> ($urandom % 32);
            win_base = $urandom;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset req_ready", 64'(req_ready), 64'd1);
        chk("R1 reset bus strobes", 64'({bus_read, bus_write}), 64'd0);
        chk("R1 reset cpl_valid", 64'(cpl_valid), 64'd0);
        rst_n = 1'b1;
        win_mask = 32'h0000_0FFF;
        win_base = 32'h8000_0000;
        for (int ph = 0; ph < 4; ph++) begin
            for (int c = 0; c < 1500; c++) begin
                @(negedge clk);
                compare_all();
                drive_random(ph * 28);
            end
        end
        @(negedge clk);
        compare_all();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule